// File: doc/BRIEF.md
# Three-Backplane LCD Segment Driver

This block multiplexes a four-and-a-half digit numeric display with sign, decimal points and two status indicators onto a liquid crystal panel that has three backplanes and twelve segment lines. Each line carries three segments, one for each backplane. The block scans the backplanes in turn. It also flips the polarity of every drive signal on alternate frames, so that no segment sees a net DC voltage.

All outputs are 2-bit level codes, not voltages. An external resistor ladder or DAC turns each code into one of four evenly spaced voltages, using one-third bias: code 3 is the highest level and code 0 the lowest. A separate one-bit annunciator drive toggles once per frame, in step with the backplanes. Any indicator that is wired to this pin turns on, and any indicator that is wired to its own backplane turns off.

The digit values, enables and flags come from latches upstream. They are read combinationally in each slot.

Top module: `lcd_tri_drv`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, slot 0 is active with positive polarity: backplane codes are (bp0,bp1,bp2) = (3,1,1), and ann = 1.
- R2: The active slot advances every SLOT_CLKS clocks, in the order 0, 1, 2. Polarity flips only when slot 2 wraps back to slot 0. A frame is three slots.
- R3: The active backplane is driven to code 3 in a positive frame and code 0 in a negative frame. Each inactive backplane is driven to code 1 in a positive frame and code 2 in a negative frame. Backplane b occupies bits [2b+1:2b] of bp_lvl.
- R4: A segment line whose segment for the active slot is on is driven to code 0 in a positive frame and 3 in a negative frame. A line whose segment is off is driven to code 2 in a positive frame and 1 in a negative frame. Line n occupies bits [2n+1:2n] of seg_lvl.
- R5: For digit i (digit 0 least significant), line 3i carries F, E and DP[i] in slots 0, 1 and 2. Line 3i+1 carries A, G and D. Line 3i+2 carries B, C and the digit's extra indicator.
- R6: Each BCD nibble bcd[4i+3:4i] is decoded to standard seven-segment patterns for 0 to 9. Nibble values 10 to 15 light no segment of that digit.
- R7: The extra indicators are assigned as follows: digit 0 carries the continuity flag, digit 1 the low-battery flag, digit 2 the minus sign, and digit 3 the leading half-digit "1".
- R8: blank[i] turns off all seven segments of digit i. Its decimal point and its extra indicator are not affected.
- R9: ann is 1 during positive frames and 0 during negative frames, so it toggles together with the backplane polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display scan clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bcd | input | 16 | Four BCD digits, digit 0 in bits [3:0] |
| blank | input | 4 | Per-digit blanking of the seven segments |
| dp_on | input | 4 | Per-digit decimal point enables |
| lead_one | input | 1 | Leading half-digit "1" segment |
| minus | input | 1 | Negative sign indicator |
| low_bat | input | 1 | Low-battery indicator |
| cont_flag | input | 1 | Continuity indicator |
| bp_lvl | output | 6 | Level codes of the three backplanes |
| seg_lvl | output | 24 | Level codes of the twelve segment lines |
| ann | output | 1 | Annunciator square-wave drive |

## Verification
The bench drives the panel with several patterns and observes each one over two whole frames, so that every slot is seen in both polarities:
- All segments on, and all segments off. These expose wrong on/off levels and wrong polarity.
- Distinct digit values with a single decimal point. These separate the segment-to-line and segment-to-slot mapping.
- Invalid BCD nibbles. These must darken their digit.
- Blanking combined with decimal points and flags. This shows that only the seven segments are suppressed.

A cycle-by-cycle walk across both frames pins the slot boundaries and the point at which the polarity flips.

// File: rtl/lcd_tri_drv.sv
module lcd_tri_drv #(
  parameter int SLOT_CLKS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bcd,
  input  logic [3:0]  blank,
  input  logic [3:0]  dp_on,
  input  logic        lead_one,
  input  logic        minus,
  input  logic        low_bat,
  input  logic        cont_flag,
  output logic [5:0]  bp_lvl,
  output logic [23:0] seg_lvl,
  output logic        ann
);
  localparam int DIGITS = 4;
  localparam int CW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

  logic [CW-1:0] cnt;
  logic [1:0]    slot;
  logic          neg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      slot <= 2'd0;
      neg  <= 1'b0;
    end else if (cnt == CW'(SLOT_CLKS - 1)) begin
      cnt <= '0;
      if (slot == 2'd2) begin
        slot <= 2'd0;
        neg  <= ~neg;
      end else begin
        slot <= slot + 2'd1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ann = ~neg;

  function automatic logic [6:0] seg7(input logic [3:0] v);
    case (v)
      4'd0: seg7 = 7'h3F;
      4'd1: seg7 = 7'h06;
      4'd2: seg7 = 7'h5B;
      4'd3: seg7 = 7'h4F;
      4'd4: seg7 = 7'h66;
      4'd5: seg7 = 7'h6D;
      4'd6: seg7 = 7'h7D;
      4'd7: seg7 = 7'h07;
      4'd8: seg7 = 7'h7F;
      4'd9: seg7 = 7'h6F;
      default: seg7 = 7'h00;
    endcase
  endfunction

  function automatic logic [1:0] line_code(input logic on, input logic n);
    line_code = on ? (n ? 2'd3 : 2'd0) : (n ? 2'd1 : 2'd2);
  endfunction

  wire [DIGITS-1:0] extra = {lead_one, minus, low_bat, cont_flag};

  genvar b, i;
  generate
    for (b = 0; b < 3; b++) begin : g_bp
      assign bp_lvl[2*b +: 2] = (slot == 2'(b)) ? (neg ? 2'd0 : 2'd3)
                                                : (neg ? 2'd2 : 2'd1);
    end

    for (i = 0; i < DIGITS; i++) begin : g_dig
      logic [6:0] s;
      logic [2:0] on;
      assign s = blank[i] ? 7'h00 : seg7(bcd[4*i +: 4]);
      always_comb begin
        case (slot)
          2'd0:    on = {s[1], s[0], s[5]};
          2'd1:    on = {s[2], s[6], s[4]};
          default: on = {extra[i], s[3], dp_on[i]};
        endcase
      end
      assign seg_lvl[6*i     +: 2] = line_code(on[0], neg);
      assign seg_lvl[6*i + 2 +: 2] = line_code(on[1], neg);
      assign seg_lvl[6*i + 4 +: 2] = line_code(on[2], neg);
    end
  endgenerate
endmodule

// File: rtl/lcd_tri_chk.sv
module lcd_tri_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  bp_lvl,
  input logic [23:0] seg_lvl,
  input logic        ann
);
  function automatic int n_select(input logic [5:0] v);
    int n = 0;
    for (int k = 0; k < 3; k++)
      if (v[2*k +: 2] == 2'd0 || v[2*k +: 2] == 2'd3) n++;
    return n;
  endfunction

  function automatic logic any_high(input logic [5:0] v);
    logic r = 1'b0;
    for (int k = 0; k < 3; k++)
      if (v[2*k +: 2] == 2'd3) r = 1'b1;
    return r;
  endfunction

  function automatic logic seg_parity_ok(input logic [23:0] v, input logic a);
    logic r = 1'b1;
    for (int k = 0; k < 12; k++)
      if (v[2*k] == a) r = 1'b0;
    return r;
  endfunction

  function automatic logic is_sel(input logic [1:0] c);
    return c == 2'd0 || c == 2'd3;
  endfunction

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    n_select(bp_lvl) == 1); // R3

  AST_ANN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ann == any_high(bp_lvl)); // R9

  AST_SEG_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    seg_parity_ok(seg_lvl, ann)); // R4

  AST_FLIP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ann) |-> (is_sel(bp_lvl[1:0]) && is_sel($past(bp_lvl[5:4])))); // R2
endmodule

bind lcd_tri_drv lcd_tri_chk u_chk (.*);

// File: tb/test_lcd_tri_drv.sv
`timescale 1ns/1ps
module test_lcd_tri_drv;
  localparam int S = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bcd = '0;
  logic [3:0]  blank = '0, dp_on = '0;
  logic        lead_one = 0, minus = 0, low_bat = 0, cont_flag = 0;
  logic [5:0]  bp_lvl;
  logic [23:0] seg_lvl;
  logic        ann;

  int n_run = 0, n_fail = 0, ticks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always @(posedge clk) ticks <= rst_n ? ticks + 1 : 0;

  lcd_tri_drv #(.SLOT_CLKS(S)) i_lcd_tri_drv (.*);

  // pattern bits: a=6 b=5 c=4 d=3 e=2 f=1 g=0
  function automatic logic [6:0] pat(input logic [3:0] v);
    case (v)
      0: return 7'b1111110; 1: return 7'b0110000; 2: return 7'b1101101;
      3: return 7'b1111001; 4: return 7'b0110011; 5: return 7'b1011011;
      6: return 7'b1011111; 7: return 7'b1110000; 8: return 7'b1111111;
      9: return 7'b1111011; default: return 7'b0;
    endcase
  endfunction

  function automatic logic [5:0] exp_bp(input int sl, input bit ng);
    logic [5:0] r;
    for (int b = 0; b < 3; b++)
      r[2*b +: 2] = (b == sl) ? (ng ? 2'd0 : 2'd3) : (ng ? 2'd2 : 2'd1);
    return r;
  endfunction

  function automatic logic [23:0] exp_seg(input int sl, input bit ng);
    logic [23:0] r;
    logic [3:0] ex;
    ex = {lead_one, minus, low_bat, cont_flag};
    for (int i = 0; i < 4; i++) begin
      logic [6:0] p;
      logic [2:0] on;
      p = blank[i] ? 7'b0 : pat(bcd[4*i +: 4]);
      case (sl)
        0: on = {p[5], p[6], p[1]};
        1: on = {p[4], p[0], p[2]};
        default: on = {ex[i], p[3], dp_on[i]};
      endcase
      for (int k = 0; k < 3; k++)
        r[6*i + 2*k +: 2] = on[k] ? (ng ? 2'd3 : 2'd0) : (ng ? 2'd1 : 2'd2);
    end
    return r;
  endfunction

  task automatic check_now(input string req);
    int sl;
    bit ng;
    sl = (ticks / S) % 3;
    ng = ((ticks / (3 * S)) % 2) == 1;
    n_run++;
    if (bp_lvl !== exp_bp(sl, ng) || ann !== !ng) begin
      n_fail++;
      $display("FAIL %s: bp_lvl=%h ann=%b expected bp_lvl=%h ann=%b",
               req, bp_lvl, ann, exp_bp(sl, ng), !ng);
    end
    n_run++;
    if (seg_lvl !== exp_seg(sl, ng)) begin
      n_fail++;
      $display("FAIL %s: seg_lvl=%h expected %h", req, seg_lvl, exp_seg(sl, ng));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_run++;
    if (bp_lvl !== 6'b010111 || ann !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: bp_lvl=%h ann=%b expected 17 1", bp_lvl, ann);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_run++;
    if (bp_lvl !== 6'b010111 || ann !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: after release bp_lvl=%h ann=%b expected 17 1", bp_lvl, ann);
    end
  endtask

  task automatic t_timing();
    for (int c = 0; c < 6 * S + 2; c++) begin
      check_now("R2 R3 R9 slot walk");
      @(negedge clk);
    end
  endtask

  task automatic t_frames(input string req);
    for (int k = 0; k < 6; k++) begin
      while (ticks % S != S / 2) @(negedge clk);
      check_now(req);
      @(negedge clk);
    end
  endtask

  task automatic t_all_on();
    bcd = 16'h8888; blank = 0; dp_on = 4'hF;
    {lead_one, minus, low_bat, cont_flag} = 4'hF;
    t_frames("R4 R5 R7 all on");
  endtask

  task automatic t_all_off();
    bcd = 16'hFFFF; blank = 0; dp_on = 0;
    {lead_one, minus, low_bat, cont_flag} = 4'h0;
    t_frames("R4 R6 all off");
  endtask

  task automatic t_digits_a();
    bcd = 16'h0123; blank = 0; dp_on = 4'b0010;
    {lead_one, minus, low_bat, cont_flag} = 4'b0100;
    t_frames("R5 R6 R7 digits 0123 minus");
  endtask

  task automatic t_digits_b();
    bcd = 16'h4567; blank = 0; dp_on = 4'b1000;
    {lead_one, minus, low_bat, cont_flag} = 4'b1001;
    t_frames("R5 R6 R7 digits 4567 lead cont");
  endtask

  task automatic t_invalid();
    bcd = 16'hAF98; blank = 0; dp_on = 4'b0100;
    {lead_one, minus, low_bat, cont_flag} = 4'b0010;
    t_frames("R6 invalid nibbles");
  endtask

  task automatic t_blank();
    bcd = 16'h8888; blank = 4'b0101; dp_on = 4'hF;
    {lead_one, minus, low_bat, cont_flag} = 4'hF;
    t_frames("R8 blank keeps dp and extra");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_timing();
    t_all_on();
    t_all_off();
    t_digits_a();
    t_digits_b();
    t_invalid();
    t_blank();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule